// File: doc/BRIEF.md
# Always-on seconds counter with power-off control

This block is an always-on real-time counter with a small power-control register. A 47-bit count advances by one on every single-cycle pulse of a 32.768 kHz tick enable. Software reaches the block through a 32-bit register window of 4 KB. Two registers expose the count. The upper word holds count bits 46:32 and the lower word holds count bits 31:0. Software can read either word, or write either word to replace that half while leaving the other half as it was. The count then carries on from the new value.

A third register holds a 32-bit power-control word. A write to this register with both the power-down-enable bit and the turn-off-power bit set raises a power-off request for exactly one clock cycle. Downstream power sequencing acts on that request. The count has its own power-on reset. The ordinary reset clears only the control word, so the time value survives a system reset.

Top module: `rtc_lp_power`

## Requirements
- R1: Each cycle with `tick_en` high and no counter write adds one to the 47-bit count. Without a tick or a write, the count holds.
- R2: A read at offset 0x24 returns count bits 46:32 in data bits 14:0 and zero in data bits 31:15.
- R3: A read at offset 0x28 returns count bits 31:0.
- R4: A write at offset 0x28 sets count bits 31:0 to the written data and keeps bits 46:32. Later ticks continue from the new value, carrying into the upper bits.
- R5: A write at offset 0x24 sets count bits 46:32 to write-data bits 14:0, drops write-data bits 31:15, and keeps count bits 31:0.
- R6: A counter write in the same cycle as a tick takes the written value, and that tick is lost.
- R7: A write at offset 0x38 stores all 32 bits, and a read at offset 0x38 returns them unchanged.
- R8: `poweroff_req` is high for exactly the one cycle after a clock edge that took an offset-0x38 write with data bit 5 (power-down enable) and data bit 6 (turn off power) both set. It is low at all other times.
- R9: `rst_n` low clears the control word to zero and leaves the count unchanged. `por_n` low clears both the count and the control word.
- R10: A read at any offset other than 0x24, 0x28 and 0x38, or at an address with bits 1:0 not zero, returns zero. A write to such an address changes no register and raises no power-off request.
- R11: The count wraps from 2^47-1 to zero on a tick.
- R12: `rd_data` is zero whenever no read request is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Active-low power-on reset; clears the count and the control word |
| rst_n | input | 1 | Active-low system reset; clears the control word only |
| tick_en | input | 1 | Single-cycle 32.768 kHz time-base pulse |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address within the 4 KB window |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid in the same cycle as the read request |
| poweroff_req | output | 1 | One-cycle power-off request |

## Verification
The count is driven by bursts of ticks from zero, by low-word preloads just below the 32-bit boundary, and by upper-word preloads at the top of the range. These three separate plain incrementing, carry into the upper word, and full 47-bit wrap. Writes that arrive together with a tick show which one wins. The control register is written with every combination of bits 5 and 6 over varied background data. This shows that the request depends only on those two bits, needs both of them, and lasts one cycle. Every byte address in the window is read and written apart from the three mapped ones, including misaligned ones, and the mapped registers are then compared with their earlier values.

// File: rtl/rtc_lp_pkg.sv
package rtc_lp_pkg;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_HI   = 2'd1,
        SEL_LO   = 2'd2,
        SEL_CTL  = 2'd3
    } reg_sel_e;

    localparam int unsigned DEF_ADDR_W  = 12;
    localparam int unsigned DEF_HI_W    = 15;
    localparam int unsigned DEF_OFF_HI  = 32'h24;
    localparam int unsigned DEF_OFF_LO  = 32'h28;
    localparam int unsigned DEF_OFF_CTL = 32'h38;
    localparam int unsigned DEF_PDE_BIT = 5;
    localparam int unsigned DEF_TOP_BIT = 6;

endpackage

// File: rtl/rtc_lp_decode.sv
module rtc_lp_decode
    import rtc_lp_pkg::*;
#(
    parameter int unsigned ADDR_W  = DEF_ADDR_W,
    parameter int unsigned OFF_HI  = DEF_OFF_HI,
    parameter int unsigned OFF_LO  = DEF_OFF_LO,
    parameter int unsigned OFF_CTL = DEF_OFF_CTL
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output reg_sel_e          sel,
    output logic              wr_hi,
    output logic              wr_lo,
    output logic              wr_ctl,
    output logic              rd_en
);
    localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(OFF_HI);
    localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(OFF_LO);
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFF_CTL);

    logic aligned;

    always_comb begin
        aligned = (req_addr[1:0] == 2'b00);
        sel     = SEL_NONE;
        if (req_valid && aligned) begin
            if (req_addr == A_HI)       sel = SEL_HI;
            else if (req_addr == A_LO)  sel = SEL_LO;
            else if (req_addr == A_CTL) sel = SEL_CTL;
        end
        wr_hi  = req_write && (sel == SEL_HI);
        wr_lo  = req_write && (sel == SEL_LO);
        wr_ctl = req_write && (sel == SEL_CTL);
        rd_en  = req_valid && !req_write;
    end

endmodule

// File: rtl/rtc_lp_counter.sv
module rtc_lp_counter #(
    parameter int unsigned HI_W = 15
) (
    input  logic                 clk,
    input  logic                 por_n,
    input  logic                 tick_en,
    input  logic                 wr_hi,
    input  logic                 wr_lo,
    input  logic [HI_W-1:0]      wdata_hi,
    input  logic [31:0]          wdata_lo,
    output logic [32+HI_W-1:0]   count
);
    localparam int unsigned CNT_W = 32 + HI_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_lo) begin
            st_d.cnt[31:0] = wdata_lo;
        end else if (wr_hi) begin
            st_d.cnt[CNT_W-1:32] = wdata_hi;
        end else if (tick_en) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;

    p_tick_inc_r1: assert property (@(posedge clk) disable iff (!por_n)
        (tick_en && !wr_hi && !wr_lo) |=> (count == $past(count) + CNT_W'(1)));

    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!por_n)
        (!tick_en && !wr_hi && !wr_lo) |=> $stable(count));

    p_lo_write_r4: assert property (@(posedge clk) disable iff (!por_n)
        wr_lo |=> ((count[31:0] == $past(wdata_lo)) &&
                   (count[CNT_W-1:32] == $past(count[CNT_W-1:32]))));

    p_hi_write_r5: assert property (@(posedge clk) disable iff (!por_n)
        wr_hi |=> ((count[CNT_W-1:32] == $past(wdata_hi)) &&
                   (count[31:0] == $past(count[31:0]))));

endmodule

// File: rtl/rtc_lp_ctl.sv
module rtc_lp_ctl #(
    parameter int unsigned PDE_BIT = 5,
    parameter int unsigned TOP_BIT = 6
) (
    input  logic        clk,
    input  logic        ctl_rst_n,
    input  logic        wr_ctl,
    input  logic [31:0] wdata,
    output logic [31:0] ctl_word,
    output logic        poweroff
);
    typedef struct packed {
        logic [31:0] ctl;
        logic        off;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.off = wr_ctl && wdata[PDE_BIT] && wdata[TOP_BIT];
        if (wr_ctl) st_d.ctl = wdata;
    end

    always_ff @(posedge clk or negedge ctl_rst_n) begin
        if (!ctl_rst_n) st_q <= '0;
        else            st_q <= st_d;
    end

    assign ctl_word = st_q.ctl;
    assign poweroff = st_q.off;

    p_ctl_store_r7: assert property (@(posedge clk) disable iff (!ctl_rst_n)
        wr_ctl |=> (ctl_word == $past(wdata)));

    p_ctl_hold_r7: assert property (@(posedge clk) disable iff (!ctl_rst_n)
        !wr_ctl |=> $stable(ctl_word));

    p_pulse_cause_r8: assert property (@(posedge clk) disable iff (!ctl_rst_n)
        poweroff |-> $past(wr_ctl && wdata[PDE_BIT] && wdata[TOP_BIT]));

    p_pulse_bits_r8: assert property (@(posedge clk) disable iff (!ctl_rst_n)
        poweroff |-> (ctl_word[PDE_BIT] && ctl_word[TOP_BIT]));

endmodule

// File: rtl/rtc_lp_power.sv
module rtc_lp_power
    import rtc_lp_pkg::*;
#(
    parameter int unsigned ADDR_W  = DEF_ADDR_W,
    parameter int unsigned HI_W    = DEF_HI_W,
    parameter int unsigned OFF_HI  = DEF_OFF_HI,
    parameter int unsigned OFF_LO  = DEF_OFF_LO,
    parameter int unsigned OFF_CTL = DEF_OFF_CTL,
    parameter int unsigned PDE_BIT = DEF_PDE_BIT,
    parameter int unsigned TOP_BIT = DEF_TOP_BIT
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic [31:0]       rd_data,
    output logic              poweroff_req
);
    localparam int unsigned CNT_W = 32 + HI_W;

    reg_sel_e         sel;
    logic             wr_hi, wr_lo, wr_ctl, rd_en;
    logic [CNT_W-1:0] count;
    logic [31:0]      ctl_word;
    logic             ctl_rst_n;

    assign ctl_rst_n = rst_n && por_n;

    rtc_lp_decode #(
        .ADDR_W (ADDR_W),
        .OFF_HI (OFF_HI),
        .OFF_LO (OFF_LO),
        .OFF_CTL(OFF_CTL)
    ) u_decode (
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .sel      (sel),
        .wr_hi    (wr_hi),
        .wr_lo    (wr_lo),
        .wr_ctl   (wr_ctl),
        .rd_en    (rd_en)
    );

    rtc_lp_counter #(
        .HI_W(HI_W)
    ) u_counter (
        .clk     (clk),
        .por_n   (por_n),
        .tick_en (tick_en),
        .wr_hi   (wr_hi),
        .wr_lo   (wr_lo),
        .wdata_hi(req_wdata[HI_W-1:0]),
        .wdata_lo(req_wdata),
        .count   (count)
    );

    rtc_lp_ctl #(
        .PDE_BIT(PDE_BIT),
        .TOP_BIT(TOP_BIT)
    ) u_ctl (
        .clk      (clk),
        .ctl_rst_n(ctl_rst_n),
        .wr_ctl   (wr_ctl),
        .wdata    (req_wdata),
        .ctl_word (ctl_word),
        .poweroff (poweroff_req)
    );

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_HI:  rd_data = {{(32-HI_W){1'b0}}, count[CNT_W-1:32]};
                SEL_LO:  rd_data = count[31:0];
                SEL_CTL: rd_data = ctl_word;
                default: rd_data = '0;
            endcase
        end
    end

    p_hi_upper_zero_r2: assert property (@(posedge clk) disable iff (!por_n)
        (rd_en && sel == SEL_HI) |-> (rd_data[31:HI_W] == '0));

    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!por_n)
        (rd_en && sel == SEL_NONE) |-> (rd_data == '0));

    p_idle_zero_r12: assert property (@(posedge clk) disable iff (!por_n)
        !req_valid |-> (rd_data == '0));

    p_one_write_r10: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0({wr_hi, wr_lo, wr_ctl}));

endmodule

// File: tb/rtc_lp_power_tb_top.sv
module rtc_lp_power_tb_top;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic        poweroff_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [46:0] exp_cnt;
    logic [31:0] exp_ctl;

    always #5 clk = ~clk;

    rtc_lp_power dut_i (
        .clk         (clk),
        .por_n       (por_n),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .rd_data     (rd_data),
        .poweroff_req(poweroff_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Drives one write; returns the request level one and two cycles later.
    task automatic do_write(input logic [11:0] a, input logic [31:0] d, input logic with_tick,
                            output logic p1, output logic p2);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; tick_en = with_tick;
        @(negedge clk);
        p1 = poweroff_req;
        req_valid = 1'b0; req_write = 1'b0; tick_en = 1'b0;
        @(negedge clk);
        p2 = poweroff_req;
    endtask

    task automatic do_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        #2;
        d = rd_data;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
            exp_cnt = exp_cnt + 47'd1;
        end
    endtask

    task automatic check_count(input string req);
        logic [31:0] v;
        do_read(12'h024, v);
        check(req, v, {17'd0, exp_cnt[46:32]});
        do_read(12'h028, v);
        check(req, v, exp_cnt[31:0]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic p1, p2;
        exp_cnt = '0;
        exp_ctl = '0;
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;

        // R9: state after power-on reset
        check_count("R9 por count");
        do_read(12'h038, v);
        check("R9 por ctl", v, 32'h0);
        check("R8 idle request", {31'd0, poweroff_req}, 32'h0);

        // R12: no request, no data
        @(negedge clk);
        #1;
        check("R12 idle rd_data", rd_data, 32'h0);

        // R1: ticks and idle hold
        ticks(5);
        check_count("R1 five ticks");
        repeat (10) @(negedge clk);
        check_count("R1 idle hold");

        // R4/R3: carry from low into high word
        do_write(12'h028, 32'hFFFF_FFFD, 1'b0, p1, p2);
        exp_cnt[31:0] = 32'hFFFF_FFFD;
        check_count("R4 R3 low write");
        ticks(3);
        check_count("R4 carry into high");

        // R5/R2: high write drops upper data bits
        do_write(12'h024, 32'hFFFF_FFFF, 1'b0, p1, p2);
        exp_cnt[46:32] = 15'h7FFF;
        do_read(12'h024, v);
        check("R2 R5 high word", v, 32'h0000_7FFF);
        do_read(12'h028, v);
        check("R5 low kept", v, 32'h0);

        // R11: full wrap
        do_write(12'h028, 32'hFFFF_FFFF, 1'b0, p1, p2);
        exp_cnt[31:0] = 32'hFFFF_FFFF;
        ticks(1);
        check("R11 wrap model", {31'd0, exp_cnt == 47'd0}, 32'h1);
        check_count("R11 wrap");

        // R6: write beats a simultaneous tick
        do_write(12'h028, 32'h0000_1234, 1'b1, p1, p2);
        exp_cnt[31:0] = 32'h0000_1234;
        check_count("R6 low write with tick");
        do_write(12'h024, 32'h0000_0022, 1'b1, p1, p2);
        exp_cnt[46:32] = 15'h0022;
        check_count("R6 high write with tick");

        // R7/R8: control combinations over background patterns
        for (int pat = 0; pat < 4; pat++) begin
            for (int combo = 0; combo < 4; combo++) begin
                logic [31:0] bg, d;
                case (pat)
                    0: bg = 32'h0000_0000;
                    1: bg = 32'hFFFF_FFFF;
                    2: bg = 32'hA5A5_A5A5;
                    default: bg = 32'h5A5A_5A5A;
                endcase
                d = (bg & ~32'h60) | (32'(combo[0]) << 5) | (32'(combo[1]) << 6);
                do_write(12'h038, d, 1'b0, p1, p2);
                exp_ctl = d;
                check("R8 pulse first cycle", {31'd0, p1}, {31'd0, combo == 3});
                check("R8 pulse ends", {31'd0, p2}, 32'h0);
                do_read(12'h038, v);
                check("R7 ctl readback", v, exp_ctl);
            end
        end

        // R10: every unmapped or misaligned address
        for (int a = 0; a < 4096; a++) begin
            if (a != 'h24 && a != 'h28 && a != 'h38) begin
                do_read(12'(a), v);
                check("R10 unmapped read", v, 32'h0);
            end
        end
        for (int a = 0; a < 4096; a++) begin
            if (a != 'h24 && a != 'h28 && a != 'h38) begin
                do_write(12'(a), 32'hFFFF_FFFF, 1'b0, p1, p2);
                if (p1 !== 1'b0 || p2 !== 1'b0)
                    check("R10 unmapped write request", {30'd0, p1, p2}, 32'h0);
            end
        end
        checks++;
        check_count("R10 count unchanged");
        do_read(12'h038, v);
        check("R10 ctl unchanged", v, exp_ctl);

        // R9: system reset clears control, keeps count
        ticks(2);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        do_read(12'h038, v);
        check("R9 rst ctl", v, 32'h0);
        check_count("R9 rst count kept");

        // R9: power-on reset clears the count
        @(negedge clk);
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        exp_cnt = '0;
        check_count("R9 por count clear");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule